// File: doc/BRIEF.md
# Accelerator Kernel Control Register Slave

This block is the single AXI4-Lite slave through which host software runs an accelerator kernel. Word 0 is a control and status word. Software writes it with bit 0 set to launch a job, then polls it. It reads bit 1 (job finished, cleared by the read) and bit 2 (core not busy). The remaining words hold the job arguments: one 64-bit base offset for each global-memory buffer, and a set of 32-bit scalars. The kernel datapath reads all of them directly as flat output buses.

Toward the kernel core the block holds a start request until the core acknowledges it. It then waits for a one-cycle finish pulse. The active-low reset is asserted asynchronously but released through a short register pipeline. The bus ports only respond once that pipeline has filled.

Top module: `kctl_regs`

## Requirements
- R1: After reset, word 0 reads 0x4 (only idle set), `start_o` is low, and every argument output is zero.
- R2: While idle, a write to byte offset 0x00 with strobe bit 0 set and data bit 0 set raises `start_o` from the cycle after the write handshake. Word 0 then reads 0x1: start set, done and idle clear.
- R3: `start_o` stays high until a cycle with `ack_i` high, and is low from the next cycle on.
- R4: A `done_i` pulse while busy (start accepted, idle low) sets done (bit 1) and idle (bit 2) in the same cycle, so word 0 then reads 0x6.
- R5: A read of word 0 returns the current done bit and clears it, so a second read returns 0x4.
- R6: If `done_i` arrives in the cycle a read of word 0 is accepted, that read returns done=0 and done stays set; the next read returns 0x6.
- R7: A start write while idle is low is ignored: word 0 is unchanged and `start_o` stays low.
- R8: Buffer i has its low 32 bits at byte offset 0x10+8*i and its high 32 bits at 0x14+8*i, driven on `buf_base_o[64*i +: 64]`.
- R9: Scalar j sits at byte offset 0x10+8*N_BUF+4*j, driven on `scalar_o[32*j +: 32]`.
- R10: Write strobe bit b updates only data byte b of the addressed argument word. A control write whose strobe bit 0 is clear does not launch.
- R11: Reads of unmapped offsets return 0. Every write and read response is OKAY (0b00).
- R12: `s_bvalid_o` and `s_rvalid_o` with their data hold until accepted. No new write or read is accepted while a response of that channel is pending.
- R13: After `rst_ni` rises, the write address is first accepted in the RST_STAGES-th clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Active-low reset, released through a pipeline |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_awaddr_i | input | ADDR_W | Write byte address |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_wdata_i | input | 32 | Write data |
| s_wstrb_i | input | 4 | Write byte strobes |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_bresp_o | output | 2 | Write response code |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_araddr_i | input | ADDR_W | Read byte address |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| s_rdata_o | output | 32 | Read data |
| s_rresp_o | output | 2 | Read response code |
| start_o | output | 1 | Job request to the core, held until acknowledged |
| ack_i | input | 1 | Core accepts the pending job |
| done_i | input | 1 | Core finish pulse |
| scalar_o | output | 32*N_SCALAR | Scalar arguments |
| buf_base_o | output | 64*N_BUF | Buffer base offsets |

## Verification
The two events that can coincide are the core's finish pulse and a software read of word 0. One sets the done bit and the other clears it. The bench raises `done_i` on exactly the cycle the read address is accepted. It then requires that this read sees done clear and that the next read sees both done and idle set, so a finish is never lost to the clear. Assertions also tie the rise of idle to the rise of done within one cycle.

// File: rtl/kctl_pkg.sv
package kctl_pkg;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned STRB_W       = WORD_W / 8;
  localparam int unsigned ARG_BASE_IDX = 4;   // first argument word, byte 0x10
  localparam logic [1:0]  RESP_OKAY    = 2'b00;

  function automatic logic [WORD_W-1:0] apply_strb(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] nxt,
    input logic [STRB_W-1:0] strb
  );
    logic [WORD_W-1:0] res;
    res = cur;
    for (int b = 0; b < STRB_W; b++)
      if (strb[b]) res[8*b +: 8] = nxt[8*b +: 8];
    return res;
  endfunction
endpackage

// File: rtl/kctl_rst_pipe.sv
module kctl_rst_pipe #(
  parameter int unsigned STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= 1'b0;
        else         pipe_q <= 1'b1;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  assign rst_no = pipe_q[STAGES-1];
endmodule

// File: rtl/kctl_ctrl_fsm.sv
module kctl_ctrl_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_wr_i,
  input  logic rd_clr_i,
  input  logic ack_i,
  input  logic done_i,
  output logic start_o,
  output logic done_o,
  output logic idle_o
);
  logic start_q, done_q, idle_q;
  logic launch, finish;

  assign launch = start_wr_i && idle_q;
  assign finish = done_i && !idle_q && !start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      idle_q  <= 1'b1;
    end else if (launch) begin
      start_q <= 1'b1;
      done_q  <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      if (start_q && ack_i) start_q <= 1'b0;
      // set beats clear-on-read so a finish is never lost
      if (finish) begin
        done_q <= 1'b1;
        idle_q <= 1'b1;
      end else if (rd_clr_i) begin
        done_q <= 1'b0;
      end
    end
  end

  assign start_o = start_q;
  assign done_o  = done_q;
  assign idle_o  = idle_q;
endmodule

// File: rtl/kctl_arg_bank.sv
module kctl_arg_bank
  import kctl_pkg::*;
#(
  parameter int unsigned N_BUF    = 2,
  parameter int unsigned N_SCALAR = 2,
  parameter int unsigned IDX_W    = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic [WORD_W-1:0]        wr_data_i,
  input  logic [STRB_W-1:0]        wr_strb_i,
  input  logic [IDX_W-1:0]         rd_idx_i,
  output logic                     rd_hit_o,
  output logic [WORD_W-1:0]        rd_word_o,
  output logic [N_SCALAR*32-1:0]   scalar_o,
  output logic [N_BUF*64-1:0]      buf_base_o
);
  localparam int unsigned NW = 2*N_BUF + N_SCALAR;

  logic [NW-1:0][WORD_W-1:0] arg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arg_q <= '0;
    end else if (wr_en_i) begin
      for (int k = 0; k < NW; k++)
        if (wr_idx_i == IDX_W'(ARG_BASE_IDX + k))
          arg_q[k] <= apply_strb(arg_q[k], wr_data_i, wr_strb_i);
    end
  end

  always_comb begin
    rd_hit_o  = 1'b0;
    rd_word_o = '0;
    for (int k = 0; k < NW; k++)
      if (rd_idx_i == IDX_W'(ARG_BASE_IDX + k)) begin
        rd_hit_o  = 1'b1;
        rd_word_o = arg_q[k];
      end
  end

  generate
    for (genvar i = 0; i < N_BUF; i++) begin : g_buf
      assign buf_base_o[64*i +: 64] = {arg_q[2*i+1], arg_q[2*i]};
    end
    for (genvar j = 0; j < N_SCALAR; j++) begin : g_scl
      assign scalar_o[32*j +: 32] = arg_q[2*N_BUF+j];
    end
  endgenerate
endmodule

// File: rtl/kctl_regs.sv
module kctl_regs
  import kctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned N_BUF      = 2,
  parameter int unsigned N_SCALAR   = 2,
  parameter int unsigned RST_STAGES = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   s_awvalid_i,
  output logic                   s_awready_o,
  input  logic [ADDR_W-1:0]      s_awaddr_i,
  input  logic                   s_wvalid_i,
  output logic                   s_wready_o,
  input  logic [31:0]            s_wdata_i,
  input  logic [3:0]             s_wstrb_i,
  output logic                   s_bvalid_o,
  input  logic                   s_bready_i,
  output logic [1:0]             s_bresp_o,
  input  logic                   s_arvalid_i,
  output logic                   s_arready_o,
  input  logic [ADDR_W-1:0]      s_araddr_i,
  output logic                   s_rvalid_o,
  input  logic                   s_rready_i,
  output logic [31:0]            s_rdata_o,
  output logic [1:0]             s_rresp_o,
  output logic                   start_o,
  input  logic                   ack_i,
  input  logic                   done_i,
  output logic [N_SCALAR*32-1:0] scalar_o,
  output logic [N_BUF*64-1:0]    buf_base_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             rst_n;
  logic             wr_go, rd_go;
  logic             bvalid_q, rvalid_q;
  logic [31:0]      rdata_q;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             ctrl_wr, rd_clr;
  logic             done_s, idle_s;
  logic             arg_hit;
  logic [31:0]      arg_word;
  logic             unused_addr_lsb;

  assign unused_addr_lsb = ^{s_awaddr_i[1:0], s_araddr_i[1:0]};

  kctl_rst_pipe #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  // write channel: address and data taken together, one response outstanding
  assign wr_go       = s_awvalid_i && s_wvalid_i && !bvalid_q && rst_n;
  assign s_awready_o = wr_go;
  assign s_wready_o  = wr_go;
  assign wr_idx      = s_awaddr_i[ADDR_W-1:2];
  assign ctrl_wr     = wr_go && (wr_idx == '0) && s_wstrb_i[0] && s_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)          bvalid_q <= 1'b0;
    else if (wr_go)      bvalid_q <= 1'b1;
    else if (s_bready_i) bvalid_q <= 1'b0;
  end

  assign s_bvalid_o = bvalid_q;
  assign s_bresp_o  = RESP_OKAY;

  // read channel
  assign rd_go       = s_arvalid_i && !rvalid_q && rst_n;
  assign s_arready_o = rd_go;
  assign rd_idx      = s_araddr_i[ADDR_W-1:2];
  assign rd_clr      = rd_go && (rd_idx == '0);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (rd_go) begin
      rvalid_q <= 1'b1;
      if (rd_idx == '0)  rdata_q <= {29'd0, idle_s, done_s, start_o};
      else if (arg_hit)  rdata_q <= arg_word;
      else               rdata_q <= '0;
    end else if (s_rready_i) begin
      rvalid_q <= 1'b0;
    end
  end

  assign s_rvalid_o = rvalid_q;
  assign s_rdata_o  = rdata_q;
  assign s_rresp_o  = RESP_OKAY;

  kctl_ctrl_fsm u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .start_wr_i(ctrl_wr),
    .rd_clr_i  (rd_clr),
    .ack_i     (ack_i),
    .done_i    (done_i),
    .start_o   (start_o),
    .done_o    (done_s),
    .idle_o    (idle_s)
  );

  kctl_arg_bank #(
    .N_BUF   (N_BUF),
    .N_SCALAR(N_SCALAR),
    .IDX_W   (IDX_W)
  ) u_args (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_go),
    .wr_idx_i  (wr_idx),
    .wr_data_i (s_wdata_i),
    .wr_strb_i (s_wstrb_i),
    .rd_idx_i  (rd_idx),
    .rd_hit_o  (arg_hit),
    .rd_word_o (arg_word),
    .scalar_o  (scalar_o),
    .buf_base_o(buf_base_o)
  );
endmodule

// File: rtl/kctl_regs_chk.sv
module kctl_regs_chk (
  input logic        clk_i,
  input logic        rst_n,
  input logic        start_o,
  input logic        ack_i,
  input logic        done_s,
  input logic        idle_s,
  input logic        s_awready_o,
  input logic        s_bvalid_o,
  input logic        s_bready_i,
  input logic [1:0]  s_bresp_o,
  input logic        s_arready_o,
  input logic        s_rvalid_o,
  input logic        s_rready_i,
  input logic [31:0] s_rdata_o,
  input logic [1:0]  s_rresp_o
);
  AST_START_NOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_o |-> !idle_s);                                              // R2
  AST_START_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_o && !ack_i |=> start_o);                                    // R3
  AST_START_DROP: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_o && ack_i |=> !start_o);                                    // R3
  AST_DONE_SETS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(done_s) |-> idle_s);                                         // R4
  AST_IDLE_ONLY_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(idle_s) |-> $rose(done_s));                                  // R4
  AST_RESP_OKAY: assert property (@(posedge clk_i) disable iff (!rst_n)
    (s_bvalid_o |-> s_bresp_o == 2'b00) and (s_rvalid_o |-> s_rresp_o == 2'b00)); // R11
  AST_BVALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    s_bvalid_o && !s_bready_i |=> s_bvalid_o);                         // R12
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    s_rvalid_o && !s_rready_i |=> s_rvalid_o && $stable(s_rdata_o));  // R12
  AST_NO_AW_WHILE_B: assert property (@(posedge clk_i) disable iff (!rst_n)
    s_bvalid_o |-> !s_awready_o);                                      // R12
  AST_NO_AR_WHILE_R: assert property (@(posedge clk_i) disable iff (!rst_n)
    s_rvalid_o |-> !s_arready_o);                                      // R12
endmodule

bind kctl_regs kctl_regs_chk u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n),
  .start_o    (start_o),
  .ack_i      (ack_i),
  .done_s     (done_s),
  .idle_s     (idle_s),
  .s_awready_o(s_awready_o),
  .s_bvalid_o (s_bvalid_o),
  .s_bready_i (s_bready_i),
  .s_bresp_o  (s_bresp_o),
  .s_arready_o(s_arready_o),
  .s_rvalid_o (s_rvalid_o),
  .s_rready_i (s_rready_i),
  .s_rdata_o  (s_rdata_o),
  .s_rresp_o  (s_rresp_o)
);

// File: tb/kctl_regs_bench.sv
`timescale 1ns/1ps
module kctl_regs_bench;
  localparam int NB = 2;
  localparam int NS = 2;
  localparam int ST = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [7:0] awaddr = 0, araddr = 0;
  logic [31:0] wdata = 0;
  logic [3:0] wstrb = 0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic start_o, ack = 0, done = 0;
  logic [NS*32-1:0] scalar_o;
  logic [NB*64-1:0] buf_base_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  kctl_regs #(.ADDR_W(8), .N_BUF(NB), .N_SCALAR(NS), .RST_STAGES(ST)) u_kctl_regs (
    .clk_i(clk), .rst_ni(rst_ni),
    .s_awvalid_i(awvalid), .s_awready_o(awready), .s_awaddr_i(awaddr),
    .s_wvalid_i(wvalid), .s_wready_o(wready), .s_wdata_i(wdata), .s_wstrb_i(wstrb),
    .s_bvalid_o(bvalid), .s_bready_i(bready), .s_bresp_o(bresp),
    .s_arvalid_i(arvalid), .s_arready_o(arready), .s_araddr_i(araddr),
    .s_rvalid_o(rvalid), .s_rready_i(rready), .s_rdata_o(rdata), .s_rresp_o(rresp),
    .start_o(start_o), .ack_i(ack), .done_i(done),
    .scalar_o(scalar_o), .buf_base_o(buf_base_o)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] patt(input int a);
    return (32'(a) * 32'h0103_0507) ^ 32'hC3A5_0F1E;
  endfunction

  function automatic bit is_arg(input int a);
    return (a >= 16) && (a < 16 + 8*NB + 4*NS);
  endfunction

  task automatic axi_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    logic hs;
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    do begin #1; hs = awready; @(posedge clk); end while (!hs);
    @(negedge clk);
    awvalid = 0; wvalid = 0; bready = 1;
    chk("R11 bresp", 64'(bresp), 64'd0);
    @(posedge clk);
    @(negedge clk);
    bready = 0;
  endtask

  task automatic axi_rd(input logic [7:0] a, output logic [31:0] d, output logic [1:0] r);
    logic hs;
    @(negedge clk);
    araddr = a; arvalid = 1;
    do begin #1; hs = arready; @(posedge clk); end while (!hs);
    @(negedge clk);
    arvalid = 0; d = rdata; r = rresp; rready = 1;
    @(posedge clk);
    @(negedge clk);
    rready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [1:0] r;
    logic hs;
    int cnt;

    // R13: readiness delayed by the reset pipeline
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 bvalid in reset", 64'(bvalid), 64'd0);
    rst_ni = 1;
    awaddr = 8'hF0; wdata = 0; wstrb = 4'hF; awvalid = 1; wvalid = 1;
    cnt = 0; hs = 0;
    while (!hs && cnt < 10) begin @(posedge clk); cnt++; #1; hs = awready; end
    chk("R13 cycles to ready", 64'(cnt), 64'(ST));
    @(posedge clk);
    @(negedge clk); awvalid = 0; wvalid = 0; bready = 1;
    @(posedge clk);
    @(negedge clk); bready = 0;

    // R1 reset state
    chk("R1 start_o", 64'(start_o), 64'd0);
    chk("R1 buf_base_o lo", buf_base_o[63:0], 64'd0);
    chk("R1 buf_base_o hi", buf_base_o[127:64], 64'd0);
    chk("R1 scalar_o", scalar_o, 64'd0);
    axi_rd(8'h00, d, r);
    chk("R1 ctrl word", 64'(d), 64'h4);

    // R10: control write without strobe bit 0 does not launch
    axi_wr(8'h00, 32'h1, 4'b1110);
    chk("R10 no launch start_o", 64'(start_o), 64'd0);
    axi_rd(8'h00, d, r);
    chk("R10 no launch ctrl", 64'(d), 64'h4);

    // R8 R9 R11: sweep every word except control
    for (int a = 4; a < 256; a += 4) axi_wr(8'(a), patt(a), 4'hF);
    for (int a = 4; a < 256; a += 4) begin
      axi_rd(8'(a), d, r);
      chk(is_arg(a) ? "R8/R9 arg readback" : "R11 unmapped zero", 64'(d),
          is_arg(a) ? 64'(patt(a)) : 64'd0);
      chk("R11 rresp", 64'(r), 64'd0);
    end
    for (int i = 0; i < NB; i++)
      chk("R8 buf_base_o", buf_base_o[64*i +: 64], {patt(20 + 8*i), patt(16 + 8*i)});
    for (int j = 0; j < NS; j++)
      chk("R9 scalar_o", 64'(scalar_o[32*j +: 32]), 64'(patt(16 + 8*NB + 4*j)));

    // R10: per-byte strobes on scalar 0
    for (int s = 0; s < 16; s++) begin
      logic [31:0] e;
      axi_wr(8'h20, 32'h0, 4'hF);
      axi_wr(8'h20, 32'hFFFF_FFFF, 4'(s));
      e = 0;
      for (int b = 0; b < 4; b++) if (s[b]) e[8*b +: 8] = 8'hFF;
      axi_rd(8'h20, d, r);
      chk("R10 strobe merge", 64'(d), 64'(e));
    end

    // R2 R3 R4 R5 R7: full job
    axi_wr(8'h00, 32'h1, 4'h1);
    chk("R2 start_o raised", 64'(start_o), 64'd1);
    axi_rd(8'h00, d, r);
    chk("R2 ctrl after launch", 64'(d), 64'h1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 start held", 64'(start_o), 64'd1);
    end
    @(negedge clk); ack = 1;
    @(posedge clk);
    @(negedge clk); ack = 0;
    chk("R3 start dropped after ack", 64'(start_o), 64'd0);
    axi_rd(8'h00, d, r);
    chk("R3 ctrl busy", 64'(d), 64'h0);
    axi_wr(8'h00, 32'h1, 4'hF);
    chk("R7 start_o ignored", 64'(start_o), 64'd0);
    axi_rd(8'h00, d, r);
    chk("R7 ctrl unchanged", 64'(d), 64'h0);
    @(negedge clk); done = 1;
    @(posedge clk);
    @(negedge clk); done = 0;
    axi_rd(8'h00, d, r);
    chk("R4 done and idle", 64'(d), 64'h6);
    axi_rd(8'h00, d, r);
    chk("R5 done cleared", 64'(d), 64'h4);

    // R6: finish pulse on the read-clear cycle
    axi_wr(8'h00, 32'h1, 4'h1);
    @(negedge clk); ack = 1;
    @(posedge clk);
    @(negedge clk); ack = 0;
    araddr = 8'h00; arvalid = 1; done = 1;
    @(posedge clk);
    @(negedge clk); arvalid = 0; done = 0; d = rdata; rready = 1;
    @(posedge clk);
    @(negedge clk); rready = 0;
    chk("R6 collision read", 64'(d), 64'h0);
    axi_rd(8'h00, d, r);
    chk("R6 done kept", 64'(d), 64'h6);
    axi_rd(8'h00, d, r);
    chk("R6 then cleared", 64'(d), 64'h4);

    // R12: write response backpressure
    @(negedge clk);
    awaddr = 8'h20; wdata = 32'h1111_1111; wstrb = 4'hF; awvalid = 1; wvalid = 1; bready = 0;
    @(posedge clk);
    @(negedge clk); wdata = 32'h2222_2222;
    for (int i = 0; i < 3; i++) begin
      chk("R12 bvalid held", 64'(bvalid), 64'd1);
      chk("R12 no aw while b pending", 64'(awready), 64'd0);
      @(negedge clk);
    end
    bready = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R12 aw ready after b", 64'(awready), 64'd1);
    @(posedge clk);
    @(negedge clk); awvalid = 0; wvalid = 0;
    @(posedge clk);
    @(negedge clk); bready = 0;
    chk("R12 second write landed", 64'(scalar_o[31:0]), 64'h2222_2222);

    // R12: read data backpressure
    araddr = 8'h20; arvalid = 1; rready = 0;
    @(posedge clk);
    @(negedge clk); araddr = 8'h24;
    for (int i = 0; i < 2; i++) begin
      chk("R12 rvalid held", 64'(rvalid), 64'd1);
      chk("R12 no ar while r pending", 64'(arready), 64'd0);
      chk("R12 rdata stable", 64'(rdata), 64'h2222_2222);
      @(negedge clk);
    end
    rready = 1;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk); arvalid = 0;
    chk("R12 queued read", 64'(rdata), 64'(patt(16 + 8*NB + 4)));
    @(posedge clk);
    @(negedge clk); rready = 0;

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule